// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block is the processor-facing half of an interrupt controller. It watches a set of level-sensitive interrupt sources, each with its own 8-bit priority (a lower value is more urgent). It picks the most urgent pending source and compares that priority with a programmable threshold. When the source passes and signalling is enabled, the block raises a registered interrupt request line towards one processor.

Software talks to the block over a simple 32-bit register bus with word addressing. Reading the acknowledge register is the handshake that claims an interrupt. The read returns the source's 10-bit ID, makes that source the single active one and removes it from the pending set. No further interrupt is signalled while a source is active. Writing the same ID to the end-of-interrupt register releases it. If a source is still asserted at that point, it becomes pending again and is signalled once more.

Top module: `ifc_cpu`

## Requirements
- R1: A read of word address 2 (acknowledge) returns, in bits [9:0], the ID of the eligible pending source with the lowest priority value. Source index i has ID BASE_ID+i, with BASE_ID = 32 by default. Among equal priorities the lower index wins, and bits [31:10] read as 0.
- R2: The acknowledge read returns the spurious ID 1023 and changes no state in three cases: signalling is disabled, no pending source passes the mask, or a source is already active.
- R3: Only a source whose priority is strictly less than the priority mask (word address 1, bits [7:0]) can be signalled or acknowledged. A priority equal to the mask is blocked.
- R4: Control bit 0 (word address 0) enables signalling. While it is 0, irq_o stays low.
- R5: A non-spurious acknowledge makes that source active and clears its pending state. irq_o is low while any source is active.
- R6: Writing the active source's ID to word address 3 (end-of-interrupt) deactivates that source. A write with any other ID is ignored, and the source stays active.
- R7: A source still asserted when its end-of-interrupt is written becomes pending again. It is then signalled and can be acknowledged again.
- R8: irq_o is a register. It changes one clock after the register write or pending update that affects it.
- R9: After reset, control reads 0, the mask reads 0 (which blocks every source), irq_o is low and no source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Level request per source |
| src_prio | input | NSRC*PW | Priority per source, index i at bits [i*PW +: PW] |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | 2 | Word address: 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume three things about the inputs: a bus access lasts exactly one cycle, a read and a write never occur in the same cycle, and the source priorities are static. The bench keeps to this. It issues every access through tasks that raise a single strobe for one cycle, and it fixes the priority vector before reset is released. Source levels only change between accesses, and the bench waits several cycles after each change so that the pending state settles before the next check.

// File: rtl/ifc_cpu_pkg.sv
package ifc_cpu_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_PMASK = 2'd1,
        REG_ACK   = 2'd2,
        REG_EOI   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ifc_cpu_pend.sv
module ifc_cpu_pend #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic [NSRC-1:0] act_mask,
    output logic [NSRC-1:0] pend_q
);
    logic [NSRC-1:0] pend_d;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_comb pend_d[i] = src_req[i] & ~act_mask[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/ifc_cpu_select.sv
module ifc_cpu_select #(
    parameter int NSRC = 8,
    parameter int PW   = 8,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]    pend,
    input  logic [NSRC*PW-1:0] prio,
    output logic               best_valid,
    output logic [IW-1:0]      best_idx,
    output logic [PW-1:0]      best_prio
);
    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_prio  = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!best_valid || prio[i*PW +: PW] < best_prio)) begin
                best_valid = 1'b1;
                best_idx   = IW'(i);
                best_prio  = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/ifc_cpu.sv
module ifc_cpu
    import ifc_cpu_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int PW      = 8,
    parameter int BASE_ID = 32,
    localparam int IW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_req,
    input  logic [NSRC*PW-1:0] src_prio,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o
);
    typedef struct packed {
        logic          en;
        logic [PW-1:0] pmask;
        logic          act_valid;
        logic [IW-1:0] act_idx;
        logic          irq;
    } state_t;

    state_t s_d, s_q;

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] act_mask;
    logic            best_valid;
    logic [IW-1:0]   best_idx;
    logic [PW-1:0]   best_prio;
    logic            eligible;
    logic [ID_W-1:0] best_id;
    logic [ID_W-1:0] act_id_q;
    logic            en_q;
    logic            act_valid_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_act
        always_comb act_mask[i] = s_q.act_valid && (s_q.act_idx == IW'(i));
    end

    ifc_cpu_pend #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .act_mask (act_mask),
        .pend_q   (pend_q)
    );

    ifc_cpu_select #(.NSRC(NSRC), .PW(PW)) u_sel (
        .pend       (pend_q),
        .prio       (src_prio),
        .best_valid (best_valid),
        .best_idx   (best_idx),
        .best_prio  (best_prio)
    );

    assign best_id     = ID_W'(BASE_ID) + ID_W'(best_idx);
    assign act_id_q    = ID_W'(BASE_ID) + ID_W'(s_q.act_idx);
    assign en_q        = s_q.en;
    assign act_valid_q = s_q.act_valid;
    assign irq_o       = s_q.irq;

    always_comb begin
        s_d       = s_q;
        eligible  = s_q.en && !s_q.act_valid && best_valid && (best_prio < s_q.pmask);
        bus_rdata = '0;

        if (bus_rd) begin
            case (reg_sel_e'(bus_addr))
                REG_CTRL:  bus_rdata = {31'd0, s_q.en};
                REG_PMASK: bus_rdata = 32'(s_q.pmask);
                REG_ACK:   bus_rdata = 32'(eligible ? best_id : SPURIOUS_ID);
                default:   bus_rdata = '0;
            endcase
            if (reg_sel_e'(bus_addr) == REG_ACK && eligible) begin
                s_d.act_valid = 1'b1;
                s_d.act_idx   = best_idx;
            end
        end

        if (bus_wr) begin
            case (reg_sel_e'(bus_addr))
                REG_CTRL:  s_d.en    = bus_wdata[0];
                REG_PMASK: s_d.pmask = bus_wdata[PW-1:0];
                REG_EOI: begin
                    if (s_q.act_valid && bus_wdata[ID_W-1:0] == act_id_q)
                        s_d.act_valid = 1'b0;
                end
                default: ;
            endcase
        end

        s_d.irq = eligible;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ifc_cpu_chk.sv
module ifc_cpu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_o,
    input logic        en_q,
    input logic        act_valid_q,
    input logic [9:0]  act_id_q
);
    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_q));

    a_r5_quiet_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_q |=> !irq_o);

    a_r2_spurious_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && act_valid_q) |-> (bus_rdata == 32'd1023));

    a_r5_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && bus_rdata[9:0] != 10'd1023) |=> act_valid_q);

    a_r6_eoi_mismatch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && act_valid_q && bus_wdata[9:0] != act_id_q)
        |=> (act_valid_q && $stable(act_id_q)));

    a_r1_id_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2) |-> (bus_rdata[31:10] == 22'd0));
endmodule

bind ifc_cpu ifc_cpu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .en_q        (en_q),
    .act_valid_q (act_valid_q),
    .act_id_q    (act_id_q)
);

// File: tb/ifc_cpu_test.sv
module ifc_cpu_test;
    localparam int NSRC = 8;
    localparam int PW   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NSRC-1:0]    src_req = '0;
    logic [NSRC*PW-1:0] src_prio;
    logic               bus_rd = 1'b0;
    logic               bus_wr = 1'b0;
    logic [1:0]         bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    ifc_cpu #(.NSRC(NSRC), .PW(PW), .BASE_ID(32)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_prio(src_prio),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s read: got %0d expected %0d", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_chk++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s irq: got %0b expected %0b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NSRC; i++) src_prio[i*PW +: PW] = 8'h80;
        src_prio[2*PW +: PW] = 8'h40;
        src_prio[5*PW +: PW] = 8'h40;
        src_prio[6*PW +: PW] = 8'hF0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state
        chk_irq(1'b0, "R9");
        rd(2'd0, 32'd0, "R9 ctrl");
        rd(2'd1, 32'd0, "R9 mask");
        rd(2'd2, 32'd1023, "R9 R2 ack");

        // R3: mask 0 blocks everything
        wr(2'd0, 32'd1);
        src_req[3] = 1'b1;
        settle();
        chk_irq(1'b0, "R3 mask zero");
        rd(2'd2, 32'd1023, "R2 none eligible");

        // R8: irq follows the mask write one clock later
        wr(2'd1, 32'hF0);
        chk_irq(1'b0, "R8 before");
        chk_irq(1'b1, "R8 after");
        rd(2'd1, 32'hF0, "R3 mask readback");

        // R1 / R5
        rd(2'd2, 32'd35, "R1 ack id");
        settle();
        chk_irq(1'b0, "R5 active");
        rd(2'd2, 32'd1023, "R5 R2 second ack");

        // R6 mismatch ignored
        wr(2'd3, 32'd36);
        settle();
        chk_irq(1'b0, "R6 wrong eoi");
        rd(2'd2, 32'd1023, "R6 still active");

        // R6 / R7 matching eoi, level still high
        wr(2'd3, 32'd35);
        settle();
        chk_irq(1'b1, "R7 re-pend");
        rd(2'd2, 32'd35, "R7 re-ack");
        src_req[3] = 1'b0;
        wr(2'd3, 32'd35);
        settle();
        chk_irq(1'b0, "R6 released");
        rd(2'd2, 32'd1023, "R6 nothing left");

        // R1 ordering: 2 and 5 at 0x40, 3 at 0x80
        src_req[2] = 1'b1; src_req[5] = 1'b1; src_req[3] = 1'b1;
        settle();
        rd(2'd2, 32'd34, "R1 tie low index");
        src_req[2] = 1'b0;
        wr(2'd3, 32'd34);
        settle();
        rd(2'd2, 32'd37, "R1 next priority");
        src_req[5] = 1'b0;
        wr(2'd3, 32'd37);
        settle();
        rd(2'd2, 32'd35, "R1 lowest priority");
        src_req[3] = 1'b0;
        wr(2'd3, 32'd35);
        settle();

        // R3 strict compare: prio 0xF0 vs mask 0xF0
        src_req[6] = 1'b1;
        settle();
        chk_irq(1'b0, "R3 equal blocked");
        rd(2'd2, 32'd1023, "R3 equal spurious");
        wr(2'd1, 32'hF1);
        settle();
        chk_irq(1'b1, "R3 below passes");
        rd(2'd2, 32'd38, "R3 ack");
        src_req[6] = 1'b0;
        wr(2'd3, 32'd38);
        settle();

        // R4 enable
        src_req[3] = 1'b1;
        wr(2'd0, 32'd0);
        settle();
        chk_irq(1'b0, "R4 disabled");
        rd(2'd0, 32'd0, "R4 ctrl readback");
        rd(2'd2, 32'd1023, "R4 R2 disabled ack");
        wr(2'd0, 32'd1);
        settle();
        chk_irq(1'b1, "R4 enabled");
        rd(2'd2, 32'd35, "R4 ack after enable");

        settle();
        finish_run();
    end
endmodule